// File: doc/BRIEF.md
# Display serial link command writer

This block takes one command request at a time and turns it into pushes on two queues that feed a display serial link host: a header queue, which takes 24-bit packet headers, and a payload queue, which takes 32-bit words. A request carries an 8-bit packet data type and a 16-bit byte count. The parameter and payload bytes arrive separately, on a valid/ready byte stream. The block sorts the data type into one of five groups:

- short commands
- read requests
- long writes
- types that are accepted but need no queue traffic
- unsupported types

For a long write it packs the incoming bytes into payload words and pushes them. It then pushes the header, which carries the byte count.

The caller reports the link power state. In the low-power stop state the writer first polls a header-queue-empty flag, up to a bounded number of polls, before it sends anything. A request made while the link is in ultra-low-power state is refused at once. Each request ends with a one-cycle completion pulse and an error flag.

Top module: `dsi_cmd_writer`

## Requirements
- R1: Long-write bytes are packed little-endian. Stream byte k of a group of four lands in bits 8k+7:8k of the payload word. One word is pushed for each four bytes.
- R2: When a long write's count is not a multiple of four, its last word carries the remaining 1, 2 or 3 bytes, and its unused upper bytes are zero.
- R3: A long write whose count is below 4 takes exactly three bytes from the stream and pushes exactly one payload word built from them.
- R4: The header word is {param1, param0, data_type} in bits 23:0. For a long write, param0 is count[7:0] and param1 is count[15:8], and the header is pushed only after the last payload word.
- R5: Data types 0x03, 0x13, 0x23, 0x05, 0x15, 0x37, 0x02, 0x12, 0x22 and 0x32 take two bytes from the stream and push one header with param0 = first byte and param1 = second byte. They push no payload.
- R6: Data types 0x04, 0x14, 0x24 and 0x06 raise irq_clear for exactly one cycle. After that they take two bytes and push a header in the same way as R5.
- R7: Data types 0x01, 0x11, 0x21, 0x31, 0x08, 0x09 and 0x19 complete without error. They push nothing and take no stream bytes.
- R8: Any data type not listed in R3 to R7 completes with done_err = 1. It pushes nothing and takes no stream bytes. Long writes are 0x29 and 0x39.
- R9: With link_state = 1 (stop), the writer polls hdr_empty once per cycle before acting. If it has not seen hdr_empty high after WAIT_LIMIT polls, it completes with an error and pushes nothing.
- R10: A request accepted with link_state = 3 (ultra-low-power) completes on the next cycle with done_err = 1 and pushes nothing. link_state = 0 and 2 skip the polling.
- R11: A push happens only in a cycle where the target queue's not-full input is high. Back-pressure stalls packing, and every byte still reaches the payload in order.
- R12: req_ready is high only while the writer is idle. done_valid is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_state | input | 2 | Link power state: 0 init, 1 stop, 2 high-speed clock on, 3 ultra-low-power |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Writer idle and able to take a request |
| req_dtype | input | 8 | Packet data type |
| req_count | input | 16 | Byte count for long writes |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Writer takes the stream byte |
| in_data | input | 8 | Stream byte |
| hdr_empty | input | 1 | Header queue is empty |
| hdr_not_full | input | 1 | Header queue can take a word |
| hdr_push | output | 1 | Header word push strobe |
| hdr_word | output | 24 | Header word |
| pay_not_full | input | 1 | Payload queue can take a word |
| pay_push | output | 1 | Payload word push strobe |
| pay_word | output | LANES*8 | Payload word (32 bits by default) |
| irq_clear | output | 1 | Pulse asking for pending interrupts to be cleared before a read request |
| done_valid | output | 1 | Request finished (one cycle) |
| done_err | output | 1 | Request was refused or timed out; valid with done_valid |

## Verification
The bench goes after three kinds of corner case.

- **Long-write tails.** It sends a count of 10, which ends in a two-byte tail, and a count of 261, which ends in a one-byte tail. A packer that shifts bytes the wrong way or leaves stale upper bytes shows up as a wrong last word.
- **Short long-write.** A count of 2 must still take three bytes and push one word. A design that trusts the count would take two bytes and leave a byte behind in the stream.
- **Order and counting.** The 261-byte case has count[15:8] = 1 and runs under queue back-pressure. The parameter split, dropped bytes and a header pushed ahead of its payload all show up there. The stop-state cases use a poll that never succeeds and one that succeeds late. A poll counter off by one, or a timeout that still pushes, shows in the error flag and in the header log.

// File: rtl/dsi_cmd_pkg.sv
package dsi_cmd_pkg;

   localparam int CNT_W  = 16;
   localparam int DT_W   = 8;
   localparam int HDR_W  = 24;

   typedef enum logic [2:0] {
      CLS_SHORT,
      CLS_READ,
      CLS_LONG,
      CLS_SILENT,
      CLS_BAD
   } dt_class_e;

   typedef enum logic [1:0] {
      LNK_INIT = 2'd0,
      LNK_STOP = 2'd1,
      LNK_HS   = 2'd2,
      LNK_ULP  = 2'd3
   } link_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_POLL,
      ST_ROUTE,
      ST_IRQ,
      ST_FILL,
      ST_HDR,
      ST_RESP
   } wr_state_e;

endpackage

// File: rtl/dsi_dtype_classifier.sv
module dsi_dtype_classifier
   import dsi_cmd_pkg::*;
(
   input  logic [DT_W-1:0] dtype,
   output dt_class_e       cls
);

   always_comb begin
      unique case (dtype)
         8'h03, 8'h13, 8'h23, 8'h05, 8'h15, 8'h37,
         8'h02, 8'h12, 8'h22, 8'h32:               cls = CLS_SHORT;
         8'h04, 8'h14, 8'h24, 8'h06:               cls = CLS_READ;
         8'h29, 8'h39:                             cls = CLS_LONG;
         8'h01, 8'h11, 8'h21, 8'h31, 8'h08,
         8'h09, 8'h19:                             cls = CLS_SILENT;
         default:                                  cls = CLS_BAD;
      endcase
   end

endmodule

// File: rtl/dsi_empty_waiter.sv
module dsi_empty_waiter #(
   parameter int WAIT_LIMIT = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic hdr_empty,
   output logic seen_empty,
   output logic expired
);

   localparam int CW = $clog2(WAIT_LIMIT + 1);

   generate
      if (WAIT_LIMIT < 1) begin : g_bad_limit
         $error("WAIT_LIMIT must be at least 1");
      end
   endgenerate

   logic          active_q;
   logic [CW-1:0] polls_q;

   assign seen_empty = active_q & hdr_empty;
   assign expired    = active_q & ~hdr_empty & (polls_q == CW'(WAIT_LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         polls_q  <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         polls_q  <= '0;
      end else if (active_q) begin
         if (seen_empty || expired) active_q <= 1'b0;
         else                       polls_q  <= polls_q + 1'b1;
      end
   end

   // R9: the poll count never passes the limit
   assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (polls_q < CW'(WAIT_LIMIT)));

endmodule

// File: rtl/dsi_word_packer.sv
module dsi_word_packer
   import dsi_cmd_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CNT_W-1:0]   nbytes,
   input  logic               emit,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   output logic               in_ready,
   input  logic               pay_not_full,
   output logic               pay_push,
   output logic [LANES*8-1:0] pay_word,
   output logic               busy,
   output logic               done
);

   localparam int LIW = (LANES > 1) ? $clog2(LANES) : 1;

   generate
      if (LANES < 3) begin : g_bad_lanes
         $error("LANES must be at least 3");
      end
   endgenerate

   logic             active_q;
   logic             full_q;
   logic [CNT_W-1:0] remain_q;
   logic [LIW-1:0]   lane_q;
   logic [7:0]       lane_byte_q [LANES];
   logic             take;
   logic             close;

   assign in_ready = active_q & ~full_q & (remain_q != '0);
   assign take     = in_valid & in_ready;
   assign close    = take & ((lane_q == LIW'(LANES - 1)) | (remain_q == CNT_W'(1)));
   assign pay_push = active_q & full_q & emit & pay_not_full;
   assign done     = active_q & full_q & (remain_q == '0) & (~emit | pay_not_full);
   assign busy     = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         full_q   <= 1'b0;
         remain_q <= '0;
         lane_q   <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         full_q   <= 1'b0;
         remain_q <= nbytes;
         lane_q   <= '0;
      end else begin
         if (take) begin
            remain_q <= remain_q - 1'b1;
            lane_q   <= close ? '0 : lane_q + 1'b1;
         end
         if (close)    full_q   <= 1'b1;
         if (pay_push) full_q   <= 1'b0;
         if (done)     active_q <= 1'b0;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                lane_byte_q[g] <= '0;
         else if (start || pay_push)                lane_byte_q[g] <= '0;
         else if (take && (lane_q == LIW'(g)))      lane_byte_q[g] <= in_data;
      end
      assign pay_word[g*8 +: 8] = lane_byte_q[g];
   end

   // R11: a word held back by a full payload queue does not change
   assert_hold_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q & full_q & emit & ~pay_not_full) |=> $stable(pay_word));

   // R2: a word starts empty after each push
   assert_tail_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_push & (remain_q != '0)) |=> (pay_word == '0));

endmodule

// File: rtl/dsi_cmd_writer.sv
module dsi_cmd_writer
   import dsi_cmd_pkg::*;
#(
   parameter int WAIT_LIMIT = 10000,
   parameter int LANES      = 4,
   localparam int PAY_W     = LANES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       link_state,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [7:0]       req_dtype,
   input  logic [15:0]      req_count,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_data,
   input  logic             hdr_empty,
   input  logic             hdr_not_full,
   output logic             hdr_push,
   output logic [23:0]      hdr_word,
   input  logic             pay_not_full,
   output logic             pay_push,
   output logic [PAY_W-1:0] pay_word,
   output logic             irq_clear,
   output logic             done_valid,
   output logic             done_err
);

   wr_state_e        state_q, state_d;
   logic [DT_W-1:0]  dtype_q;
   logic [CNT_W-1:0] count_q;
   dt_class_e        cls_d, cls_q;
   logic             err_q, err_d;
   logic             accept;
   logic             wait_start, seen_empty, expired;
   logic             pk_start, pk_emit, pk_busy, pk_done;
   logic [CNT_W-1:0] pk_nbytes;
   logic [7:0]       prm0, prm1;

   dsi_dtype_classifier u_class (.dtype(req_dtype), .cls(cls_d));

   dsi_empty_waiter #(.WAIT_LIMIT(WAIT_LIMIT)) u_wait (
      .clk, .rst_n, .start(wait_start), .hdr_empty,
      .seen_empty, .expired
   );

   dsi_word_packer #(.LANES(LANES)) u_pack (
      .clk, .rst_n, .start(pk_start), .nbytes(pk_nbytes), .emit(pk_emit),
      .in_valid, .in_data, .in_ready, .pay_not_full, .pay_push, .pay_word,
      .busy(pk_busy), .done(pk_done)
   );

   assign req_ready  = (state_q == ST_IDLE);
   assign accept     = req_valid & req_ready;
   assign wait_start = accept & (link_state == LNK_STOP);
   assign pk_emit    = (cls_q == CLS_LONG);
   assign pk_nbytes  = (cls_q != CLS_LONG)           ? CNT_W'(2) :
                       (count_q < CNT_W'(LANES))      ? CNT_W'(3) : count_q;
   assign pk_start   = ((state_q == ST_ROUTE) & ((cls_q == CLS_SHORT) | (cls_q == CLS_LONG)))
                     | (state_q == ST_IRQ);
   assign irq_clear  = (state_q == ST_IRQ);
   assign prm0       = pk_emit ? count_q[7:0]  : pay_word[7:0];
   assign prm1       = pk_emit ? count_q[15:8] : pay_word[15:8];
   assign hdr_word   = {prm1, prm0, dtype_q};
   assign hdr_push   = (state_q == ST_HDR) & hdr_not_full;
   assign done_valid = (state_q == ST_RESP);
   assign done_err   = done_valid & err_q;

   always_comb begin
      state_d = state_q;
      err_d   = err_q;
      unique case (state_q)
         ST_IDLE: if (accept) begin
            err_d = 1'b0;
            if (link_state == LNK_ULP) begin
               err_d   = 1'b1;
               state_d = ST_RESP;
            end else if (link_state == LNK_STOP) state_d = ST_POLL;
            else                                 state_d = ST_ROUTE;
         end
         ST_POLL: begin
            if (seen_empty) state_d = ST_ROUTE;
            else if (expired) begin
               err_d   = 1'b1;
               state_d = ST_RESP;
            end
         end
         ST_ROUTE: begin
            unique case (cls_q)
               CLS_SHORT, CLS_LONG: state_d = ST_FILL;
               CLS_READ:            state_d = ST_IRQ;
               CLS_SILENT:          state_d = ST_RESP;
               default: begin
                  err_d   = 1'b1;
                  state_d = ST_RESP;
               end
            endcase
         end
         ST_IRQ:  state_d = ST_FILL;
         ST_FILL: if (pk_done) state_d = ST_HDR;
         ST_HDR:  if (hdr_push) state_d = ST_RESP;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         err_q   <= 1'b0;
         dtype_q <= '0;
         count_q <= '0;
         cls_q   <= CLS_BAD;
      end else begin
         state_q <= state_d;
         err_q   <= err_d;
         if (accept) begin
            dtype_q <= req_dtype;
            count_q <= req_count;
            cls_q   <= cls_d;
         end
      end
   end

   // R4: the header never goes out while payload packing is still running
   assert_hdr_after_payload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_push |-> !pk_busy);

   // R6: the interrupt-clear request is a single-cycle pulse
   assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clear |=> !irq_clear);

   // R10: an ultra-low-power request is refused on the next cycle
   assert_ulp_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && link_state == LNK_ULP) |=> (done_valid && done_err));

   // R12: the completion is a single-cycle pulse
   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   // R8: no queue traffic while a refusal is reported
   assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_err |-> !(hdr_push || pay_push));

endmodule

// File: tb/dsi_cmd_writer_tb.sv
module dsi_cmd_writer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WLIM       = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  link_state = 2'd2;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_dtype = '0;
   logic [15:0] req_count = '0;
   logic        in_valid, in_ready;
   logic [7:0]  in_data;
   logic        hdr_empty = 1'b1;
   logic        hdr_not_full = 1'b1;
   logic        hdr_push;
   logic [23:0] hdr_word;
   logic        pay_not_full;
   logic        pay_push;
   logic [31:0] pay_word;
   logic        irq_clear, done_valid, done_err;

   int checks = 0, failures = 0;
   int cyc = 0;
   logic stall_en = 1'b0;

   logic [7:0]  src_mem [300];
   int          src_len = 0, src_idx = 0;
   logic [31:0] pay_log [80];
   logic [23:0] hdr_log [4];
   int pay_n = 0, hdr_n = 0, irq_n = 0, ev = 0, pay_ev = 0, hdr_ev = 0, irq_ev = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign in_valid     = (src_idx < src_len);
   assign in_data      = (src_idx < 300) ? src_mem[src_idx] : 8'h00;
   assign pay_not_full = !stall_en || (cyc % 3 == 0);

   dsi_cmd_writer #(.WAIT_LIMIT(WLIM), .LANES(4)) u_dut (
      .clk, .rst_n, .link_state, .req_valid, .req_ready, .req_dtype, .req_count,
      .in_valid, .in_ready, .in_data, .hdr_empty, .hdr_not_full, .hdr_push,
      .hdr_word, .pay_not_full, .pay_push, .pay_word, .irq_clear,
      .done_valid, .done_err
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (in_valid && in_ready) src_idx <= src_idx + 1;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (pay_push) begin
            if (pay_n < 80) pay_log[pay_n] = pay_word;
            pay_n++; ev++; pay_ev = ev;
         end
         if (hdr_push) begin
            if (hdr_n < 4) hdr_log[hdr_n] = hdr_word;
            hdr_n++; ev++; hdr_ev = ev;
         end
         if (irq_clear) begin
            irq_n++; ev++; irq_ev = ev;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic prep(input int len);
      @(negedge clk);
      pay_n = 0; hdr_n = 0; irq_n = 0; ev = 0; pay_ev = 0; hdr_ev = 0; irq_ev = 0;
      src_idx = 0; src_len = len;
   endtask

   task automatic run_req(input logic [7:0] dt, input logic [15:0] cnt,
                          input logic [1:0] ls, output logic err);
      logic got;
      got = 1'b0; err = 1'b0;
      @(negedge clk);
      link_state = ls; req_dtype = dt; req_count = cnt; req_valid = 1'b1;
      chk("R12 req_ready while idle", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 3000 && !got; i++) begin
         if (done_valid) begin
            got = 1'b1; err = done_err;
         end else @(negedge clk);
      end
      chk("R12 completion seen", {31'd0, got}, 32'd1);
      @(negedge clk);
      chk("R12 single completion pulse", {31'd0, done_valid}, 32'd0);
   endtask

   task automatic t_reset();
      chk("R12 reset req_ready", {31'd0, req_ready}, 32'd1);
      chk("R12 reset done_valid", {31'd0, done_valid}, 32'd0);
      chk("R11 reset no push", {30'd0, hdr_push, pay_push}, 32'd0);
   endtask

   task automatic t_long_ten();
      logic e;
      prep(10);
      for (int i = 0; i < 10; i++) src_mem[i] = 8'(i + 1);
      run_req(8'h39, 16'd10, 2'd2, e);
      chk("R1 err", {31'd0, e}, 32'd0);
      chk("R1 word count", pay_n, 32'd3);
      chk("R1 word0", pay_log[0], 32'h04030201);
      chk("R1 word1", pay_log[1], 32'h08070605);
      chk("R2 tail word", pay_log[2], 32'h00000A09);
      chk("R4 header", {8'd0, hdr_log[0]}, 32'h00000A39);
      chk("R4 header after payload", {31'd0, hdr_ev > pay_ev}, 32'd1);
   endtask

   task automatic t_long_short();
      logic e;
      prep(4);
      src_mem[0] = 8'hAA; src_mem[1] = 8'hBB; src_mem[2] = 8'hCC; src_mem[3] = 8'hDD;
      run_req(8'h29, 16'd2, 2'd0, e);
      chk("R3 one word", pay_n, 32'd1);
      chk("R3 word", pay_log[0], 32'h00CCBBAA);
      chk("R3 bytes taken", src_idx, 32'd3);
      chk("R4 header count 2", {8'd0, hdr_log[0]}, 32'h00000229);
   endtask

   task automatic t_long_big_stall();
      logic e;
      prep(261);
      for (int i = 0; i < 261; i++) src_mem[i] = 8'(i);
      stall_en = 1'b1;
      run_req(8'h39, 16'd261, 2'd2, e);
      stall_en = 1'b0;
      chk("R11 word count under stall", pay_n, 32'd66);
      chk("R11 bytes taken", src_idx, 32'd261);
      chk("R1 first word", pay_log[0], 32'h03020100);
      chk("R11 word 64", pay_log[64], 32'h03020100);
      chk("R2 one-byte tail", pay_log[65], 32'h00000004);
      chk("R4 header high count byte", {8'd0, hdr_log[0]}, 32'h00010539);
   endtask

   task automatic t_short();
      logic e;
      prep(2);
      src_mem[0] = 8'h36; src_mem[1] = 8'h08;
      run_req(8'h15, 16'd0, 2'd2, e);
      chk("R5 err", {31'd0, e}, 32'd0);
      chk("R5 no payload", pay_n, 32'd0);
      chk("R5 one header", hdr_n, 32'd1);
      chk("R5 header", {8'd0, hdr_log[0]}, 32'h00083615);
      chk("R6 no irq for short", irq_n, 32'd0);
   endtask

   task automatic t_read();
      logic e;
      prep(2);
      src_mem[0] = 8'h0A; src_mem[1] = 8'h00;
      run_req(8'h06, 16'd0, 2'd2, e);
      chk("R6 irq pulses", irq_n, 32'd1);
      chk("R6 irq before header", {31'd0, irq_ev < hdr_ev}, 32'd1);
      chk("R6 header", {8'd0, hdr_log[0]}, 32'h00000A06);
      chk("R6 no payload", pay_n, 32'd0);
   endtask

   task automatic t_silent();
      logic e;
      prep(1);
      src_mem[0] = 8'h55;
      run_req(8'h09, 16'd4, 2'd2, e);
      chk("R7 err", {31'd0, e}, 32'd0);
      chk("R7 no pushes", pay_n + hdr_n, 32'd0);
      chk("R7 no bytes taken", src_idx, 32'd0);
   endtask

   task automatic t_bad();
      logic e;
      prep(1);
      src_mem[0] = 8'h55;
      run_req(8'h3E, 16'd4, 2'd2, e);
      chk("R8 err", {31'd0, e}, 32'd1);
      chk("R8 no pushes", pay_n + hdr_n, 32'd0);
      chk("R8 no bytes taken", src_idx, 32'd0);
   endtask

   task automatic t_ulp();
      logic e;
      prep(2);
      src_mem[0] = 8'h01; src_mem[1] = 8'h02;
      run_req(8'h05, 16'd0, 2'd3, e);
      chk("R10 err", {31'd0, e}, 32'd1);
      chk("R10 no pushes", pay_n + hdr_n, 32'd0);
   endtask

   task automatic t_stop_timeout();
      logic e;
      prep(2);
      src_mem[0] = 8'h01; src_mem[1] = 8'h02;
      hdr_empty = 1'b0;
      run_req(8'h05, 16'd0, 2'd1, e);
      chk("R9 timeout err", {31'd0, e}, 32'd1);
      chk("R9 timeout no pushes", pay_n + hdr_n, 32'd0);
      hdr_empty = 1'b1;
   endtask

   task automatic t_stop_late();
      logic e;
      prep(2);
      src_mem[0] = 8'h11; src_mem[1] = 8'h22;
      hdr_empty = 1'b0;
      fork
         begin
            repeat (WLIM - 4) @(negedge clk);
            hdr_empty = 1'b1;
         end
      join_none
      run_req(8'h13, 16'd0, 2'd1, e);
      chk("R9 late empty ok", {31'd0, e}, 32'd0);
      chk("R9 late empty header", {8'd0, hdr_log[0]}, 32'h00221113);
      hdr_empty = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_long_ten();
      t_long_short();
      t_long_big_stall();
      t_short();
      t_read();
      t_silent();
      t_bad();
      t_ulp();
      t_stop_timeout();
      t_stop_late();
      finish_run();
   end

endmodule